// File: doc/BRIEF.md
# Cassette Tape Block Transmitter

This block turns bytes from a host into a complete cassette recording signal. On a block command it takes a block type and a length (0 to 255). It emits a leading 0x55, the sync byte 0x3C, the type, the length, the data bytes and the 8-bit checksum, then a trailing 0x55. The data bytes come from the host through a valid/ready handshake. On a separate leader command it emits a run of 0x55 bytes with no framing around them. The host sequences name, data and end-of-file blocks, and it times the silent gaps between them.

Each bit leaves the block as exactly one cycle of a square tone. A one is a single short cycle and a zero is a cycle twice as long, so the bit time depends on the bit value. All timing comes from a clock-enable divider built from the system clock. The single-bit output is meant to drive an external attenuator.

Top module: `cas_block_tx`

## Requirements
- R1: With HALF = CLK_HZ / (2 * HI_HZ) clocks, a 1 bit is sent as `tone_out` high for HALF clocks and then low for HALF clocks.
- R2: A 0 bit is sent as `tone_out` high for 2*HALF clocks and then low for 2*HALF clocks.
- R3: Within each byte, bits go out least significant bit first. Every byte is preceded by exactly one clock of low output while the shifter reloads. In the data phase that gap lasts until the host supplies the byte.
- R4: A block command sends, in this order: 0x55, 0x3C, the type byte, the length byte, the data bytes in the order accepted, the checksum and 0x55.
- R5: The checksum byte is (type + length + sum of all data bytes) modulo 256.
- R6: With length 0, the checksum follows the length byte directly and `data_ready` is never asserted during that block.
- R7: A leader command sends LEADER_BYTES (default 128) bytes of 0x55 and nothing else.
- R8: `busy` rises on the clock edge that accepts a command. It falls one clock after the final low half-cycle of the last byte. While `busy` is low, `tone_out` is low.
- R9: `data_ready` is high only in the data phase while the shifter is empty. A byte is taken on a clock edge where `data_valid` and `data_ready` are both high. While `data_valid` stays low, the block waits with the output low.
- R10: Commands that arrive while `busy` is high are ignored. When `leader_go` and `blk_go` arrive together while idle, the leader is sent.
- R11: After reset, `busy`, `tone_out` and `data_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| leader_go | input | 1 | One-clock request for a leader run |
| blk_go | input | 1 | One-clock request for a framed block |
| blk_kind | input | 8 | Block type byte, sampled with `blk_go` |
| blk_len | input | 8 | Data byte count, sampled with `blk_go` |
| data_in | input | 8 | Data byte offered by the host |
| data_valid | input | 1 | `data_in` holds a byte |
| data_ready | output | 1 | Block takes `data_in` at the next edge if valid |
| busy | output | 1 | A leader or block is in progress |
| tone_out | output | 1 | Square-wave tone for the recorder |

## Verification
The hardest case to reach from the ports is a host that holds back a data byte after `data_ready` rises. The reload gap must then stretch by exactly the stall while the tone stays low and the frame loses nothing. The stimulus counts `data_ready` cycles and keeps `data_valid` low for a set number of them before it offers the first byte of a name block. The reference model stretches its expected gap to match. Mid-frame commands, simultaneous commands and a 255-byte block whose checksum wraps several times are also driven. A zero-length block is sent to confirm that the handshake never opens.

// File: rtl/cas_tx_pkg.sv
package cas_tx_pkg;

    localparam logic [7:0] LEAD_BYTE = 8'h55;
    localparam logic [7:0] SYNC_BYTE = 8'h3C;
    localparam logic [7:0] KIND_NAME = 8'h00;
    localparam logic [7:0] KIND_DATA = 8'h01;
    localparam logic [7:0] KIND_EOF  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HEAD,
        ST_SYNC,
        ST_KIND,
        ST_LEN,
        ST_DATA,
        ST_SUM,
        ST_TAIL,
        ST_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic [7:0] kind;
        logic [7:0] len;
    } blk_hdr_t;

    // last half-period index of a bit: a one spans 2 halves, a zero 4
    function automatic logic [1:0] last_half(input logic bit_val);
        return bit_val ? 2'd1 : 2'd3;
    endfunction

    // high during the first half of the bit's single tone cycle
    function automatic logic half_level(input logic bit_val, input logic [1:0] half_idx);
        return bit_val ? (half_idx == 2'd0) : (half_idx[1] == 1'b0);
    endfunction

    function automatic logic [7:0] sum8(input logic [7:0] a, input logic [7:0] b);
        return a + b;
    endfunction

endpackage

// File: rtl/cas_tone_div.sv
module cas_tone_div #(
    parameter int HALF_DIV = 10416
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/cas_bit_shifter.sv
module cas_bit_shifter
    import cas_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tick,
    output logic       full,
    output logic       tone
);
    logic       full_q;
    logic [7:0] sh;
    logic [2:0] bidx;
    logic [1:0] half;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            sh     <= '0;
            bidx   <= '0;
            half   <= '0;
        end else if (load && !full_q) begin
            full_q <= 1'b1;
            sh     <= load_byte;
            bidx   <= '0;
            half   <= '0;
        end else if (full_q && tick) begin
            if (half == last_half(sh[0])) begin
                half <= '0;
                sh   <= {1'b0, sh[7:1]};
                bidx <= bidx + 1'b1;
                if (bidx == 3'd7) begin
                    full_q <= 1'b0;
                end
            end else begin
                half <= half + 1'b1;
            end
        end
    end

    assign full = full_q;
    assign tone = full_q && half_level(sh[0], half);

    AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        load |-> !full_q); // R9
    AST_ONE_BIT_TWO_HALVES: assert property (@(posedge clk) disable iff (rst)
        (full_q && sh[0]) |-> (half <= 2'd1)); // R1
    AST_BYTE_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> !$past(tone)); // R2

endmodule

// File: rtl/cas_frame_seq.sv
module cas_frame_seq
    import cas_tx_pkg::*;
#(
    parameter int LEADER_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       leader_go,
    input  logic       blk_go,
    input  logic [7:0] blk_kind,
    input  logic [7:0] blk_len,
    input  logic [7:0] data_in,
    input  logic       data_valid,
    output logic       data_ready,
    input  logic       sh_full,
    output logic       sh_load,
    output logic [7:0] sh_byte,
    output logic       busy
);
    localparam int LCW = $clog2(LEADER_BYTES + 1);

    seq_state_e     state;
    blk_hdr_t       hdr;
    logic [LCW-1:0] lead_left;
    logic [7:0]     rem;
    logic [7:0]     csum;
    logic           slot_free;

    assign slot_free = !sh_full;

    always_comb begin
        sh_load    = 1'b0;
        sh_byte    = LEAD_BYTE;
        data_ready = 1'b0;
        case (state)
            ST_LEAD, ST_HEAD, ST_TAIL: sh_load = slot_free;
            ST_SYNC: begin
                sh_load = slot_free;
                sh_byte = SYNC_BYTE;
            end
            ST_KIND: begin
                sh_load = slot_free;
                sh_byte = hdr.kind;
            end
            ST_LEN: begin
                sh_load = slot_free;
                sh_byte = hdr.len;
            end
            ST_DATA: begin
                data_ready = slot_free;
                sh_load    = slot_free && data_valid;
                sh_byte    = data_in;
            end
            ST_SUM: begin
                sh_load = slot_free;
                sh_byte = csum;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hdr       <= '0;
            lead_left <= '0;
            rem       <= '0;
            csum      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (leader_go) begin
                        lead_left <= LCW'(LEADER_BYTES);
                        state     <= ST_LEAD;
                    end else if (blk_go) begin
                        hdr   <= '{kind: blk_kind, len: blk_len};
                        rem   <= blk_len;
                        csum  <= sum8(blk_kind, blk_len);
                        state <= ST_HEAD;
                    end
                end
                ST_LEAD: if (sh_load) begin
                    lead_left <= lead_left - 1'b1;
                    if (lead_left == LCW'(1)) state <= ST_DRAIN;
                end
                ST_HEAD: if (sh_load) state <= ST_SYNC;
                ST_SYNC: if (sh_load) state <= ST_KIND;
                ST_KIND: if (sh_load) state <= ST_LEN;
                ST_LEN:  if (sh_load) state <= (hdr.len == 8'd0) ? ST_SUM : ST_DATA;
                ST_DATA: if (sh_load) begin
                    csum <= sum8(csum, data_in);
                    rem  <= rem - 1'b1;
                    if (rem == 8'd1) state <= ST_SUM;
                end
                ST_SUM:  if (sh_load) state <= ST_TAIL;
                ST_TAIL: if (sh_load) state <= ST_DRAIN;
                ST_DRAIN: if (!sh_full) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    AST_NO_READY_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (busy && state != ST_LEAD && hdr.len == 8'd0) |-> !data_ready); // R6
    AST_HDR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(hdr)); // R10
    AST_IDLE_SHIFTER_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sh_full); // R8

endmodule

// File: rtl/cas_block_tx.sv
module cas_block_tx #(
    parameter int CLK_HZ       = 50_000_000,
    parameter int HI_HZ        = 2400,
    parameter int LEADER_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       leader_go,
    input  logic       blk_go,
    input  logic [7:0] blk_kind,
    input  logic [7:0] blk_len,
    input  logic [7:0] data_in,
    input  logic       data_valid,
    output logic       data_ready,
    output logic       busy,
    output logic       tone_out
);
    localparam int HALF_DIV = CLK_HZ / (2 * HI_HZ);

    logic       sh_full;
    logic       sh_load;
    logic [7:0] sh_byte;
    logic       tick;

    cas_frame_seq #(.LEADER_BYTES(LEADER_BYTES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .leader_go  (leader_go),
        .blk_go     (blk_go),
        .blk_kind   (blk_kind),
        .blk_len    (blk_len),
        .data_in    (data_in),
        .data_valid (data_valid),
        .data_ready (data_ready),
        .sh_full    (sh_full),
        .sh_load    (sh_load),
        .sh_byte    (sh_byte),
        .busy       (busy)
    );

    cas_tone_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (sh_full),
        .tick (tick)
    );

    cas_bit_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (sh_byte),
        .tick      (tick),
        .full      (sh_full),
        .tone      (tone_out)
    );

    AST_TONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        tone_out |-> busy); // R8

endmodule

// File: tb/test_cas_block_tx.sv
module test_cas_block_tx;
    localparam int CLK_HZ = 19200;
    localparam int HI_HZ  = 2400;
    localparam int HALF   = CLK_HZ / (2 * HI_HZ);
    localparam int LB     = 128;
    localparam int WD     = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       leader_go = 1'b0;
    logic       blk_go = 1'b0;
    logic [7:0] blk_kind = '0;
    logic [7:0] blk_len = '0;
    logic [7:0] data_in = '0;
    logic       data_valid = 1'b0;
    logic       data_ready, busy, tone_out;

    always #10 clk = ~clk;

    cas_block_tx #(.CLK_HZ(CLK_HZ), .HI_HZ(HI_HZ), .LEADER_BYTES(LB)) i_cas_block_tx (
        .clk(clk), .rst(rst), .leader_go(leader_go), .blk_go(blk_go),
        .blk_kind(blk_kind), .blk_len(blk_len), .data_in(data_in),
        .data_valid(data_valid), .data_ready(data_ready), .busy(busy),
        .tone_out(tone_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_cnt = 0;
    bit wd_hit = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] data_q[$];
    int  didx = 0;
    bit  acc_pend = 0;
    int  stall_left = 0;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic push(input logic t, input logic b, input logic r, input string tag);
        exp_q.push_back({t, b, r});
        tag_q.push_back(tag);
    endtask

    // expected waveform of one byte: gap clocks, then one tone cycle per bit, LSB first
    task automatic push_byte(input logic [7:0] v, input int gap, input logic gap_rdy, input string role);
        for (int g = 0; g < gap; g++) push(1'b0, 1'b1, gap_rdy, {role, " R3 gap"});
        for (int k = 0; k < 8; k++) begin
            int units;
            string bt;
            units = v[k] ? 1 : 2;
            bt = v[k] ? "R1" : "R2";
            for (int c = 0; c < HALF * units; c++) push(1'b1, 1'b1, 1'b0, {role, " ", bt});
            for (int c = 0; c < HALF * units; c++) push(1'b0, 1'b1, 1'b0, {role, " ", bt});
        end
    endtask

    task automatic expect_frame(input logic [7:0] kind, input logic [7:0] len, input int stall);
        int s;
        s = kind + len;
        push_byte(8'h55, 1, 1'b0, "R4");
        push_byte(8'h3C, 1, 1'b0, "R4");
        push_byte(kind, 1, 1'b0, "R4");
        push_byte(len, 1, 1'b0, "R4");
        for (int i = 0; i < len; i++) begin
            push_byte(data_q[i], (i == 0 && stall > 1) ? stall : 1, 1'b1, "R9");
            s = s + data_q[i];
        end
        push_byte(8'(s % 256), 1, 1'b0, "R5");
        push_byte(8'h55, 1, 1'b0, "R4");
        push(1'b0, 1'b1, 1'b0, "R8 drain");
    endtask

    task automatic expect_leader();
        for (int i = 0; i < LB; i++) push_byte(8'h55, 1, 1'b0, "R7");
        push(1'b0, 1'b1, 1'b0, "R8 drain");
    endtask

    task automatic tick();
        logic [2:0] e;
        string t;
        @(negedge clk);
        cyc++;
        if (!rst) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = 3'b000;
                t = "R8 idle";
            end
            checks++;
            if ({tone_out, busy, data_ready} !== e) begin
                errors++;
                $display("FAIL %s cycle %0d: {tone,busy,ready} got %b expected %b",
                         t, cyc, {tone_out, busy, data_ready}, e);
            end
            if (data_ready) rdy_cnt++;
        end
        if (acc_pend) didx++;
        if (data_ready && stall_left > 0) stall_left--;
        data_valid = (stall_left == 0) && (didx < data_q.size());
        data_in    = data_valid ? data_q[didx] : 8'h00;
        acc_pend   = data_ready && data_valid;
        if (cyc > WD && !wd_hit) begin
            wd_hit = 1;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WD);
            finish_run();
        end
    endtask

    task automatic wait_done();
        while (exp_q.size() > 0) tick();
        repeat (3) tick();
        check(busy == 1'b0, "R8 busy low after frame", busy, 0);
    endtask

    task automatic send_block(input logic [7:0] kind, input logic [7:0] len, input int stall);
        didx = 0;
        acc_pend = 0;
        stall_left = stall;
        blk_kind = kind;
        blk_len = len;
        blk_go = 1'b1;
        expect_frame(kind, len, stall);
        tick();
        blk_go = 1'b0;
        blk_kind = 8'h00;
        blk_len = 8'h00;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        check(busy == 1'b0, "R11 busy after reset", busy, 0);
        check(tone_out == 1'b0, "R11 tone after reset", tone_out, 0);
        check(data_ready == 1'b0, "R11 ready after reset", data_ready, 0);
        repeat (4) tick();

        // leader run
        leader_go = 1'b1;
        expect_leader();
        tick();
        leader_go = 1'b0;
        wait_done();

        // short data block with mixed bit patterns
        data_q = '{8'hA5, 8'h00, 8'hFF};
        send_block(8'h01, 8'd3, 0);
        wait_done();

        // end-of-file block, zero length: handshake must stay closed
        data_q.delete();
        rdy_cnt = 0;
        send_block(8'hFF, 8'd0, 0);
        wait_done();
        check(rdy_cnt == 0, "R6 ready cycles in zero-length block", rdy_cnt, 0);

        // name block, host stalls the first byte for 5 ready cycles
        data_q.delete();
        for (int i = 0; i < 15; i++) data_q.push_back(8'(8'h41 + i));
        rdy_cnt = 0;
        send_block(8'h00, 8'd15, 5);
        wait_done();
        check(rdy_cnt == 19, "R9 ready cycles with stall", rdy_cnt, 19);

        // long block, checksum wraps many times
        data_q.delete();
        for (int i = 0; i < 255; i++) data_q.push_back(8'((i * 7 + 3) % 256));
        send_block(8'h01, 8'd255, 0);
        wait_done();

        // commands during a frame are ignored
        data_q = '{8'h3C, 8'hC3};
        send_block(8'h01, 8'd2, 0);
        repeat (50) tick();
        check(busy == 1'b1, "R10 busy mid-frame", busy, 1);
        leader_go = 1'b1;
        blk_go = 1'b1;
        blk_kind = 8'h77;
        blk_len = 8'd9;
        tick();
        leader_go = 1'b0;
        blk_go = 1'b0;
        repeat (40) tick();
        blk_go = 1'b1;
        tick();
        blk_go = 1'b0;
        wait_done();

        // simultaneous commands while idle: leader wins
        data_q.delete();
        didx = 0;
        acc_pend = 0;
        rdy_cnt = 0;
        leader_go = 1'b1;
        blk_go = 1'b1;
        blk_kind = 8'h01;
        blk_len = 8'd4;
        expect_leader();
        tick();
        leader_go = 1'b0;
        blk_go = 1'b0;
        wait_done();
        check(rdy_cnt == 0, "R10 no data phase when leader wins", rdy_cnt, 0);

        finish_run();
    end

endmodule